// File: doc/BRIEF.md
# Byte/Word Logic, Shift and Rotate Unit

This block performs the bit-manipulation part of a byte/word integer datapath. Each request supplies two operands, a size select, a 4-bit operation code, two candidate shift counts and the current flags. The block returns a result, a write-enable for the destination and the updated flags. It covers Boolean operations, a flag-only TEST, zero-fill and sign-fill shifts, plain rotates, and rotates through the carry flag.

The request is taken on a one-cycle strobe. One clock later the registered result, write-enable and flags appear with an output valid pulse. The shift or rotate distance comes from either an immediate field or a count-register value, selected per request, and only its low five bits are used. Decode, register access, memory operands and arithmetic are handled elsewhere in the datapath.

Top module: `bitop_unit`

## Requirements
- R1: A request with `in_valid` high at a clock edge produces `out_valid` high after that edge. With `in_valid` low, `out_valid` and `wr_en` are low after the edge, and `result` and `flags_out` keep their values.
- R2: While `rst_n` is low at a clock edge, `out_valid`, `wr_en`, `result` and `flags_out` become zero after that edge, whatever the other inputs are.
- R3: Size select: with `is_word`=1 all 16 bits take part. With `is_word`=0 only bits 7:0 of the operands take part, `result[15:8]` is zero, SF is taken from result bit 7, and ZF is taken from result bits 7:0.
- R4: Codes NOT=0, AND=1, OR=2, XOR=3 produce the complement of A, A&B, A|B and A^B, each with `wr_en`=1. NOT passes `flags_in` through unchanged.
- R5: The flags vector has CF at bit 0, PF at bit 1, ZF at bit 2, SF at bit 3 and OF at bit 4. AND, OR, XOR and TEST clear CF and OF. They set ZF when the sized result is zero, SF from the sign bit of the result, and PF when bits 7:0 of the result hold an even number of ones.
- R6: TEST (code 4) returns A&B on `result` and sets flags as in R5, with `wr_en`=0.
- R7: The count is `reg_count` when `count_from_reg`=1 and `imm_count` otherwise. Only its bits 4:0 are used, so the distance is 0 to 31.
- R8: SHL (code 5) fills with zeros from the right. SHR (code 6) fills with zeros from the left. SAR (code 7) fills with copies of the sign bit. For a nonzero count, CF is the last bit shifted out, and ZF, SF and PF follow R5's rules on the result.
- R9: ROL (code 8) and ROR (code 9) rotate within the 8- or 16-bit operand. For a nonzero count, CF is the last bit carried around: the new bit 0 for ROL and the new sign bit for ROR. ZF, SF and PF are unchanged.
- R10: RCL (code 10) and RCR (code 11) rotate a 9-bit (byte) or 17-bit (word) ring made of the carry flag above the operand. After the move, the operand part is the result and the top ring bit is CF. ZF, SF and PF are unchanged.
- R11: With a count of exactly 1, OF is set as follows. For SHL, ROL and RCL it is the new sign bit XOR the new CF. For SHR it is the original sign bit. For SAR it is 0. For ROR and RCR it is the XOR of the two top result bits. For counts above 1, OF keeps its incoming value.
- R12: For codes 5 to 11 with a count of zero, the result is the sized operand A, `wr_en`=1, and all flags equal `flags_in`.
- R13: Codes 12 to 15 are reserved. They return a zero result with `wr_en`=0 and flags equal to `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| is_word | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| op | input | 4 | Operation code |
| opnd_a | input | 16 | Destination operand, also the operand that is shifted or rotated |
| opnd_b | input | 16 | Second operand for Boolean operations |
| imm_count | input | 8 | Count taken from the instruction immediate |
| reg_count | input | 8 | Count taken from the count register |
| count_from_reg | input | 1 | Selects `reg_count` as the count source |
| flags_in | input | 5 | Incoming flags {OF,SF,ZF,PF,CF}; CF is the carry into the ring |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 16 | Registered result |
| wr_en | output | 1 | Destination write-enable for this result |
| flags_out | output | 5 | Registered flags {OF,SF,ZF,PF,CF} |

## Verification
The hardest case to reach from the ports is a carry ring that wraps past its own length. An example is a byte RCL whose masked count is 9 or more, so that the ring returns to or passes its starting point while CF travels through the operand. Directed requests place counts of 9, 17, 18 and 31 on the ring, and on plain rotates counts that are exact multiples of the width. Some of these are fed through the register path with high bits set above the five used bits, so that masking and modulo reduction are exercised together. A pseudo-random stream then varies size, operation, count source and incoming carry, and idle gaps are mixed in to check that the outputs hold.

// File: rtl/bitop_pkg.sv
// Shared definitions for the logic, shift and rotate unit.
// Assumes a 4-bit operation code and a 5-bit flags vector {OF,SF,ZF,PF,CF}.
package bitop_pkg;

    localparam int OP_W   = 4;
    localparam int FLAG_W = 5;

    // Operation codes; 12..15 are reserved
    localparam logic [OP_W-1:0] OP_NOT  = 4'd0;
    localparam logic [OP_W-1:0] OP_AND  = 4'd1;
    localparam logic [OP_W-1:0] OP_OR   = 4'd2;
    localparam logic [OP_W-1:0] OP_XOR  = 4'd3;
    localparam logic [OP_W-1:0] OP_TEST = 4'd4;
    localparam logic [OP_W-1:0] OP_SHL  = 4'd5;
    localparam logic [OP_W-1:0] OP_SHR  = 4'd6;
    localparam logic [OP_W-1:0] OP_SAR  = 4'd7;
    localparam logic [OP_W-1:0] OP_ROL  = 4'd8;
    localparam logic [OP_W-1:0] OP_ROR  = 4'd9;
    localparam logic [OP_W-1:0] OP_RCL  = 4'd10;
    localparam logic [OP_W-1:0] OP_RCR  = 4'd11;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic pf;
        logic cf;
    } bitop_flags_t;

    // True for the Boolean operations that rewrite CF/OF/ZF/SF/PF
    function automatic logic is_bool_flag_op(logic [OP_W-1:0] op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_TEST);
    endfunction

    // True for any shift or rotate
    function automatic logic is_move_op(logic [OP_W-1:0] op);
        return (op >= OP_SHL) && (op <= OP_RCR);
    endfunction

    // True for the three shifts, which also rewrite ZF/SF/PF
    function automatic logic is_shift_op(logic [OP_W-1:0] op);
        return (op >= OP_SHL) && (op <= OP_SAR);
    endfunction

endpackage

// File: rtl/bitop_count_sel.sv
// Picks the move distance from the immediate or the count register.
// Assumes only the low CW bits are meaningful; the upper bits are dropped.
module bitop_count_sel #(
    parameter int IN_W = 8,
    parameter int CW   = 5
) (
    input  logic [IN_W-1:0] imm_cnt,
    input  logic [IN_W-1:0] reg_cnt,
    input  logic            use_reg,
    output logic [CW-1:0]   cnt
);

    // Source select followed by truncation to the usable range
    always_comb begin
        cnt = use_reg ? reg_cnt[CW-1:0] : imm_cnt[CW-1:0];
    end

endmodule

// File: rtl/bitop_logic.sv
// Boolean datapath: complement, and, or, xor (TEST shares the and path).
// Assumes the caller masks the result to the active operand size.
module bitop_logic
    import bitop_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]    res
);

    // Boolean function select; every other code reuses the and path
    always_comb begin
        case (op)
            OP_NOT:  res = ~a;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = a & b;
        endcase
    end

endmodule

// File: rtl/bitop_shifter.sv
// Single-pass shifter and rotator for one operand width W.
// Shifts use one barrel stage with one guard bit, which catches the last bit out.
// Plain rotates reduce the count modulo W, and carry rotates modulo W+1.
// Also returns the overflow value that applies when the count is exactly one.
// Assumes cnt is nonzero when its outputs are used; the caller handles zero.
module bitop_shifter
    import bitop_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic [W-1:0]    a,
    input  logic            cf_in,
    input  logic [OP_W-1:0] op,
    input  logic [CW-1:0]   cnt,
    output logic [W-1:0]    res,
    output logic            cf_out,
    output logic            of_one
);

    localparam int RING_W = W + 1;

    logic [W:0]        shl_v;
    logic [W:0]        shr_v;
    logic signed [W:0] sar_v;
    logic [CW-1:0]     rot_n;
    logic [CW-1:0]     ring_n;
    logic [W-1:0]      rol_v;
    logic [W-1:0]      ror_v;
    logic [W:0]        ring;
    logic [W:0]        rcl_v;
    logic [W:0]        rcr_v;

    // Guard-bit shifts: the extra bit holds the last bit moved out
    assign shl_v = {1'b0, a} << cnt;
    assign shr_v = {a, 1'b0} >> cnt;
    assign sar_v = $signed({a, 1'b0}) >>> cnt;

    // Effective rotate distances after wrap-around
    assign rot_n  = CW'(int'(cnt) % W);
    assign ring_n = CW'(int'(cnt) % RING_W);

    // Plain rotates inside the operand
    assign rol_v = (a << rot_n) | (a >> (W - int'(rot_n)));
    assign ror_v = (a >> rot_n) | (a << (W - int'(rot_n)));

    // Carry ring: CF sits above the operand's sign bit
    assign ring  = {cf_in, a};
    assign rcl_v = (ring << ring_n) | (ring >> (RING_W - int'(ring_n)));
    assign rcr_v = (ring >> ring_n) | (ring << (RING_W - int'(ring_n)));

    // Per-operation result, carry and single-step overflow
    always_comb begin
        res    = a;
        cf_out = cf_in;
        of_one = 1'b0;
        case (op)
            OP_SHL: begin
                res    = shl_v[W-1:0];
                cf_out = shl_v[W];
                of_one = shl_v[W-1] ^ shl_v[W];
            end
            OP_SHR: begin
                res    = shr_v[W:1];
                cf_out = shr_v[0];
                of_one = a[W-1];
            end
            OP_SAR: begin
                res    = sar_v[W:1];
                cf_out = sar_v[0];
                of_one = 1'b0;
            end
            OP_ROL: begin
                res    = rol_v;
                cf_out = rol_v[0];
                of_one = rol_v[W-1] ^ rol_v[0];
            end
            OP_ROR: begin
                res    = ror_v;
                cf_out = ror_v[W-1];
                of_one = ror_v[W-1] ^ ror_v[W-2];
            end
            OP_RCL: begin
                res    = rcl_v[W-1:0];
                cf_out = rcl_v[W];
                of_one = rcl_v[W-1] ^ rcl_v[W];
            end
            OP_RCR: begin
                res    = rcr_v[W-1:0];
                cf_out = rcr_v[W];
                of_one = rcr_v[W-1] ^ rcr_v[W-2];
            end
            default: begin
                res    = a;
                cf_out = cf_in;
                of_one = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bitop_unit.sv
// Byte/word logic, shift and rotate unit (top).
// Takes a request on in_valid and returns the registered result, write-enable
// and flags one clock later. Byte and word shifters run in parallel, and the
// size select picks between them. Assumes WORD_W is twice the byte width and
// that the 5-bit flag layout from bitop_pkg is used. Synchronous reset, active low.
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int CNT_W    = 5,
    parameter int CNT_IN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                is_word,
    input  logic [OP_W-1:0]     op,
    input  logic [WORD_W-1:0]   opnd_a,
    input  logic [WORD_W-1:0]   opnd_b,
    input  logic [CNT_IN_W-1:0] imm_count,
    input  logic [CNT_IN_W-1:0] reg_count,
    input  logic                count_from_reg,
    input  logic [FLAG_W-1:0]   flags_in,
    output logic                out_valid,
    output logic [WORD_W-1:0]   result,
    output logic                wr_en,
    output logic [FLAG_W-1:0]   flags_out
);

    localparam int BYTE_W = WORD_W / 2;
    localparam logic [WORD_W-1:0] BYTE_MASK = {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] size_mask;
    logic [WORD_W-1:0] a_sized;
    logic [WORD_W-1:0] lg_res;
    logic [WORD_W-1:0] sh_res [2];
    logic              sh_cf  [2];
    logic              sh_of  [2];
    bitop_flags_t      fl_in;
    bitop_flags_t      nxt_fl;
    bitop_flags_t      fl_q;
    logic [WORD_W-1:0] nxt_res;
    logic              nxt_we;

    // Zero, sign and parity flags from a sized value
    function automatic bitop_flags_t with_zsp(bitop_flags_t f, logic [WORD_W-1:0] v, logic wide);
        bitop_flags_t o;
        o    = f;
        o.zf = (v == '0);
        o.sf = wide ? v[WORD_W-1] : v[BYTE_W-1];
        o.pf = ~^v[BYTE_W-1:0];
        return o;
    endfunction

    bitop_count_sel #(
        .IN_W (CNT_IN_W),
        .CW   (CNT_W)
    ) u_cnt (
        .imm_cnt (imm_count),
        .reg_cnt (reg_count),
        .use_reg (count_from_reg),
        .cnt     (cnt)
    );

    bitop_logic #(
        .W (WORD_W)
    ) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .op  (op),
        .res (lg_res)
    );

    // One shifter per operand size: index 0 is byte, index 1 is word
    for (genvar g = 0; g < 2; g++) begin : g_size
        localparam int SW = (g == 0) ? BYTE_W : WORD_W;
        logic [SW-1:0] r_s;

        bitop_shifter #(
            .W  (SW),
            .CW (CNT_W)
        ) u_sh (
            .a      (opnd_a[SW-1:0]),
            .cf_in  (flags_in[0]),
            .op     (op),
            .cnt    (cnt),
            .res    (r_s),
            .cf_out (sh_cf[g]),
            .of_one (sh_of[g])
        );

        assign sh_res[g] = WORD_W'(r_s);
    end

    assign fl_in     = bitop_flags_t'(flags_in);
    assign size_mask = is_word ? {WORD_W{1'b1}} : BYTE_MASK;
    assign a_sized   = opnd_a & size_mask;

    // Next-state selection of result, write-enable and flags
    always_comb begin
        nxt_res = '0;
        nxt_we  = 1'b0;
        nxt_fl  = fl_in;
        if (op == OP_NOT) begin
            nxt_res = lg_res & size_mask;
            nxt_we  = 1'b1;
        end else if (is_bool_flag_op(op)) begin
            nxt_res   = lg_res & size_mask;
            nxt_we    = (op != OP_TEST);
            nxt_fl    = with_zsp(fl_in, lg_res & size_mask, is_word);
            nxt_fl.cf = 1'b0;
            nxt_fl.of = 1'b0;
        end else if (is_move_op(op)) begin
            nxt_we = 1'b1;
            if (cnt == '0) begin
                nxt_res = a_sized;
            end else begin
                nxt_res = sh_res[is_word];
                if (is_shift_op(op)) begin
                    nxt_fl = with_zsp(fl_in, sh_res[is_word], is_word);
                end
                nxt_fl.cf = sh_cf[is_word];
                if (cnt == CNT_W'(1)) begin
                    nxt_fl.of = sh_of[is_word];
                end
            end
        end
    end

    // Output registers: capture on the strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            result    <= '0;
            fl_q      <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid & nxt_we;
            if (in_valid) begin
                result <= nxt_res;
                fl_q   <= nxt_fl;
            end
        end
    end

    assign flags_out = fl_q;

endmodule

// File: rtl/bitop_unit_sva.sv
// Property checker for bitop_unit, attached with bind. It observes ports only.
module bitop_unit_sva
    import bitop_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int CNT_W    = 5,
    parameter int CNT_IN_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                is_word,
    input logic [OP_W-1:0]     op,
    input logic [WORD_W-1:0]   opnd_a,
    input logic [CNT_IN_W-1:0] imm_count,
    input logic [CNT_IN_W-1:0] reg_count,
    input logic                count_from_reg,
    input logic [FLAG_W-1:0]   flags_in,
    input logic                out_valid,
    input logic [WORD_W-1:0]   result,
    input logic                wr_en,
    input logic [FLAG_W-1:0]   flags_out
);

    localparam int BYTE_W = WORD_W / 2;

    logic [WORD_W-1:0] a_view;
    logic              zero_cnt;

    assign a_view   = is_word ? opnd_a : {{(WORD_W-BYTE_W){1'b0}}, opnd_a[BYTE_W-1:0]};
    assign zero_cnt = count_from_reg ? (reg_count[CNT_W-1:0] == '0) : (imm_count[CNT_W-1:0] == '0);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && $stable(result) && $stable(flags_out)));

    assert_reset_clear_R2: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !wr_en && result == '0 && flags_out == '0));

    assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_word) |=> (result[WORD_W-1:BYTE_W] == '0));

    assert_not_keeps_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_NOT) |=> (flags_out == $past(flags_in) && wr_en));

    assert_bool_clears_cf_of_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_TEST))
        |=> (!flags_out[0] && !flags_out[4]));

    assert_test_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_TEST) |=> !wr_en);

    assert_rotate_keeps_zsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !zero_cnt && (op == OP_ROL || op == OP_ROR || op == OP_RCL || op == OP_RCR))
        |=> (flags_out[3:1] == $past(flags_in[3:1])));

    assert_zero_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_cnt && op >= OP_SHL && op <= OP_RCR)
        |=> (result == $past(a_view) && flags_out == $past(flags_in) && wr_en));

    assert_reserved_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > OP_RCR) |=> (!wr_en && result == '0 && flags_out == $past(flags_in)));

endmodule

bind bitop_unit bitop_unit_sva #(
    .WORD_W   (WORD_W),
    .CNT_W    (CNT_W),
    .CNT_IN_W (CNT_IN_W)
) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .is_word        (is_word),
    .op             (op),
    .opnd_a         (opnd_a),
    .imm_count      (imm_count),
    .reg_count      (reg_count),
    .count_from_reg (count_from_reg),
    .flags_in       (flags_in),
    .out_valid      (out_valid),
    .result         (result),
    .wr_en          (wr_en),
    .flags_out      (flags_out)
);

// File: tb/tb_bitop_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes expected items with a stepwise model
// and queues them. The monitor pops one item per output valid and compares it.
module tb_bitop_unit;

    typedef struct {
        logic [15:0] r;
        logic        we;
        logic [4:0]  f;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        is_word = 1'b0;
    logic [3:0]  op = '0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [7:0]  imm_count = '0;
    logic [7:0]  reg_count = '0;
    logic        count_from_reg = 1'b0;
    logic [4:0]  flags_in = '0;
    logic        out_valid;
    logic [15:0] result;
    logic        wr_en;
    logic [4:0]  flags_out;

    int          checks = 0;
    int          errors = 0;
    exp_t        q[$];
    logic        seen = 1'b0;
    logic [15:0] last_r;
    logic [4:0]  last_f;
    logic [31:0] seed = 32'h1234_5678;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    bitop_unit dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .is_word        (is_word),
        .op             (op),
        .opnd_a         (opnd_a),
        .opnd_b         (opnd_b),
        .imm_count      (imm_count),
        .reg_count      (reg_count),
        .count_from_reg (count_from_reg),
        .flags_in       (flags_in),
        .out_valid      (out_valid),
        .result         (result),
        .wr_en          (wr_en),
        .flags_out      (flags_out)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Stepwise model taken from the requirements, one position per iteration
    task automatic model(input logic [3:0] o, input logic w, input logic [15:0] a, input logic [15:0] b,
                         input logic [4:0] cnt, input logic [4:0] fin,
                         output logic [15:0] r, output logic we, output logic [4:0] fo);
        int n;
        logic [15:0] m, v, orig;
        logic c, nb;
        n  = w ? 16 : 8;
        m  = w ? 16'hFFFF : 16'h00FF;
        v  = a & m;
        orig = v;
        c  = fin[0];
        fo = fin;
        we = 1'b1;
        r  = '0;
        if (o == 4'd0) begin
            r = ~a & m;
        end else if (o <= 4'd4) begin
            case (o)
                4'd2:    v = (a | b) & m;
                4'd3:    v = (a ^ b) & m;
                default: v = (a & b) & m;
            endcase
            r = v;
            we = (o != 4'd4);
            fo[0] = 1'b0;
            fo[4] = 1'b0;
            fo[2] = (v == 16'h0);
            fo[3] = v[n-1];
            fo[1] = ~^v[7:0];
        end else if (o <= 4'd11) begin
            for (int i = 0; i < int'(cnt); i++) begin
                case (o)
                    4'd5: begin c = v[n-1]; v = (v << 1) & m; end
                    4'd6: begin c = v[0]; v = v >> 1; end
                    4'd7: begin c = v[0]; v = (v >> 1) | (v & (16'h1 << (n-1))); end
                    4'd8: begin c = v[n-1]; v = ((v << 1) | {15'b0, c}) & m; end
                    4'd9: begin c = v[0]; v = (v >> 1) | ({15'b0, c} << (n-1)); end
                    4'd10: begin nb = v[n-1]; v = ((v << 1) | {15'b0, c}) & m; c = nb; end
                    default: begin nb = v[0]; v = (v >> 1) | ({15'b0, c} << (n-1)); c = nb; end
                endcase
            end
            r = v;
            if (cnt != 0) begin
                fo[0] = c;
                if (cnt == 1) begin
                    case (o)
                        4'd6:           fo[4] = orig[n-1];
                        4'd7:           fo[4] = 1'b0;
                        4'd9, 4'd11:    fo[4] = v[n-1] ^ v[n-2];
                        default:        fo[4] = v[n-1] ^ c;
                    endcase
                end
                if (o <= 4'd7) begin
                    fo[2] = (v == 16'h0);
                    fo[3] = v[n-1];
                    fo[1] = ~^v[7:0];
                end
            end
        end else begin
            we = 1'b0;
        end
    endtask

    // Driver: apply one request at the falling edge and queue its expectation
    task automatic send(input logic [3:0] o, input logic w, input logic [15:0] a, input logic [15:0] b,
                        input logic [7:0] ic, input logic [7:0] rc, input logic fr,
                        input logic [4:0] fi, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        op = o; is_word = w; opnd_a = a; opnd_b = b;
        imm_count = ic; reg_count = rc; count_from_reg = fr; flags_in = fi;
        model(o, w, a, b, fr ? rc[4:0] : ic[4:0], fi, e.r, e.we, e.f);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic string tag_of(input logic [3:0] o, input logic [4:0] cnt);
        if (o <= 4'd3) return "R4";
        if (o == 4'd4) return "R6";
        if (o >= 4'd12) return "R13";
        if (cnt == 0) return "R12";
        if (cnt == 1) return "R11";
        if (o <= 4'd7) return "R8";
        if (o <= 4'd9) return "R9";
        return "R10";
    endfunction

    // Monitor: compare each output against the head of the queue, and check hold when idle
    always begin
        exp_t e;
        @(posedge clk);
        #2;
        if (rst_n && !done) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk("R1", "unexpected out_valid", 16'h1, 16'h0);
                end else begin
                    e = q.pop_front();
                    chk(e.tag, "result", result, e.r);
                    chk(e.tag, "wr_en", {15'b0, wr_en}, {15'b0, e.we});
                    chk(e.tag, "flags", {11'b0, flags_out}, {11'b0, e.f});
                end
                seen   = 1'b1;
                last_r = result;
                last_f = flags_out;
            end else if (seen) begin
                chk("R1", "hold result", result, last_r);
                chk("R1", "hold flags/wr_en", {10'b0, wr_en, flags_out}, {11'b0, last_f});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R2: reset holds outputs at zero even with a request present
        @(negedge clk);
        in_valid = 1'b1; op = 4'd1; is_word = 1'b1; opnd_a = 16'hFFFF; opnd_b = 16'hFFFF; flags_in = 5'h1F;
        repeat (3) @(posedge clk);
        #2;
        chk("R2", "reset out_valid/wr_en", {14'b0, out_valid, wr_en}, 16'h0);
        chk("R2", "reset result", result, 16'h0);
        chk("R2", "reset flags", {11'b0, flags_out}, 16'h0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);

        // R4 word Boolean results
        send(4'd0, 1'b1, 16'h0F0F, 16'h0000, 8'd0, 8'd0, 1'b0, 5'h15, "R4");
        send(4'd1, 1'b1, 16'hF0F0, 16'hFF00, 8'd0, 8'd0, 1'b0, 5'h1F, "R4");
        send(4'd2, 1'b1, 16'h8001, 16'h0100, 8'd0, 8'd0, 1'b0, 5'h00, "R4");
        send(4'd3, 1'b1, 16'hAAAA, 16'hAAAA, 8'd0, 8'd0, 1'b0, 5'h1F, "R5");
        // R5 parity: 0x03 has even ones, 0x07 odd
        send(4'd1, 1'b0, 16'h1203, 16'h00FF, 8'd0, 8'd0, 1'b0, 5'h11, "R5");
        send(4'd1, 1'b0, 16'h0007, 16'h00FF, 8'd0, 8'd0, 1'b0, 5'h00, "R5");
        // R6 TEST
        send(4'd4, 1'b1, 16'h8000, 16'hC000, 8'd0, 8'd0, 1'b0, 5'h11, "R6");
        // R3 byte mode ignores upper bits, sign from bit 7
        send(4'd2, 1'b0, 16'hFF80, 16'hAA00, 8'd0, 8'd0, 1'b0, 5'h00, "R3");
        send(4'd0, 1'b0, 16'h12FF, 16'h0000, 8'd0, 8'd0, 1'b0, 5'h0A, "R3");
        idle(2);
        // R7 count source and masking
        send(4'd5, 1'b1, 16'h0001, 16'h0, 8'd1, 8'd3, 1'b1, 5'h00, "R7");
        send(4'd5, 1'b1, 16'h0001, 16'h0, 8'd2, 8'd9, 1'b0, 5'h00, "R7");
        send(4'd6, 1'b1, 16'h8000, 16'h0, 8'd0, 8'h23, 1'b1, 5'h00, "R7");
        send(4'd8, 1'b0, 16'h0081, 16'h0, 8'h20, 8'd1, 1'b0, 5'h1F, "R12");
        // R8 shift boundaries
        send(4'd7, 1'b0, 16'h0080, 16'h0, 8'd7, 8'd0, 1'b0, 5'h00, "R8");
        send(4'd7, 1'b0, 16'h0080, 16'h0, 8'd31, 8'd0, 1'b0, 5'h00, "R8");
        send(4'd5, 1'b1, 16'hFFFF, 16'h0, 8'd16, 8'd0, 1'b0, 5'h00, "R8");
        send(4'd5, 1'b1, 16'hFFFF, 16'h0, 8'd17, 8'd0, 1'b0, 5'h1F, "R8");
        send(4'd6, 1'b1, 16'h8001, 16'h0, 8'd16, 8'd0, 1'b0, 5'h00, "R8");
        // R9 rotates at width multiples
        send(4'd8, 1'b0, 16'h0081, 16'h0, 8'd8, 8'd0, 1'b0, 5'h0E, "R9");
        send(4'd9, 1'b1, 16'h0001, 16'h0, 8'd16, 8'd0, 1'b0, 5'h00, "R9");
        send(4'd9, 1'b1, 16'h1234, 16'h0, 8'd4, 8'd0, 1'b0, 5'h00, "R9");
        // R10 carry ring wrap
        send(4'd10, 1'b0, 16'h0055, 16'h0, 8'd9, 8'd0, 1'b0, 5'h01, "R10");
        send(4'd10, 1'b0, 16'h0080, 16'h0, 8'd1, 8'hE9, 1'b1, 5'h00, "R10");
        send(4'd11, 1'b1, 16'h0001, 16'h0, 8'd17, 8'd0, 1'b0, 5'h00, "R10");
        send(4'd11, 1'b1, 16'h0001, 16'h0, 8'd18, 8'd0, 1'b0, 5'h00, "R10");
        send(4'd10, 1'b0, 16'h00C3, 16'h0, 8'd31, 8'd0, 1'b0, 5'h01, "R10");
        // R11 single-step overflow
        send(4'd5, 1'b0, 16'h0040, 16'h0, 8'd1, 8'd0, 1'b0, 5'h00, "R11");
        send(4'd6, 1'b1, 16'h8000, 16'h0, 8'd1, 8'd0, 1'b0, 5'h00, "R11");
        send(4'd7, 1'b1, 16'h8000, 16'h0, 8'd1, 8'd0, 1'b0, 5'h10, "R11");
        send(4'd9, 1'b0, 16'h0001, 16'h0, 8'd1, 8'd0, 1'b0, 5'h00, "R11");
        send(4'd11, 1'b1, 16'h0000, 16'h0, 8'd1, 8'd0, 1'b0, 5'h01, "R11");
        send(4'd5, 1'b0, 16'h0040, 16'h0, 8'd2, 8'd0, 1'b0, 5'h10, "R11");
        // R13 reserved codes
        send(4'd12, 1'b1, 16'hFFFF, 16'hFFFF, 8'd3, 8'd0, 1'b0, 5'h0B, "R13");
        send(4'd15, 1'b0, 16'h00FF, 16'h0, 8'd0, 8'd0, 1'b0, 5'h14, "R13");
        idle(3);

        // Pseudo-random stream with idle gaps
        for (int k = 0; k < 1500; k++) begin
            logic [31:0] x, y, z;
            logic [3:0]  o;
            logic        fr;
            logic [7:0]  ic, rc;
            x = rnd(); y = rnd(); z = rnd();
            o  = x[3:0];
            fr = x[4];
            ic = z[7:0];
            rc = z[15:8];
            send(o, x[5], y[15:0], y[31:16], ic, rc, fr, x[12:8], tag_of(o, fr ? rc[4:0] : ic[4:0]));
            if (x[20:18] == 3'd0) idle(int'(x[22:21]) + 1);
        end
        idle(4);
        chk("R1", "queue drained", 16'(q.size()), 16'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule